// File: doc/BRIEF.md
# Serial Controller Register Set with Interrupt Priority

This block is the processor-side register file of a classic byte-wide serial controller. A host reads and writes eight byte registers through a 3-bit offset with one-cycle read and write strobes. The registers are: a transmit/receive data port, an interrupt enable mask, an interrupt identifier, line format control, modem control, line status, modem status and a scratch byte. A control bit in the line format register switches offsets 0 and 1 over to a 16-bit clock divisor. The divisor, the word length and the break request are driven out to a separate baud generator and shifter.

On the line side, a written byte leaves on a byte-out port with a one-cycle valid pulse. The shifter reports completion on a done pulse. Incoming bytes arrive on a valid/ready port that holds off while an unread byte is waiting. A separate break pulse loads a zero byte and flags a break. Two interrupt causes are ranked, received data above transmitter-empty, and they drive a level interrupt output. A loopback mode turns written bytes back into the receiver and reflects the modem-control outputs in the modem-status register.

Top module: `sercon_regs`

## Requirements
- R1: After reset the register at offset 2 reads 0x01, offset 5 reads 0x60, offset 6 reads 0xB0, and offsets 0, 1, 3, 4 and 7 read 0x00.
- R2: While offset 3 bit 7 is set, offsets 0 and 1 read and write the low and high divisor bytes, the `divisor` output carries the 16-bit value, and a write to offset 0 sends no byte.
- R3: Offset 2 reads 0x04 when a received byte is waiting and offset 1 bit 0 is set; otherwise 0x02 when the transmit-pending flag is set and offset 1 bit 1 is set; otherwise 0x01.
- R4: `irq` is high exactly when offset 2 would read a value other than 0x01.
- R5: A read of offset 2 that returns 0x02 clears the transmit-pending flag, so the next read gives the next lower cause.
- R6: Writing offset 0 with offset 3 bit 7 clear and loopback off clears offset 5 bits 6 and 5 and the pending flag, and drives `tx_byte` with `tx_valid` high for the one cycle after the write. A `tx_done` pulse sets bits 6 and 5 again and sets the pending flag.
- R7: Writing offset 1 while offset 5 bit 5 is set sets the transmit-pending flag.
- R8: Reading offset 0 with offset 3 bit 7 clear clears offset 5 bit 0 (data ready) and bit 4 (break).
- R9: `rx_ready` is the inverse of data ready. A byte offered while it is low leaves the held byte unchanged, and an accepted byte sets data ready.
- R10: A `brk_rx` pulse loads 0x00 as the received byte and sets offset 5 bits 4 and 0.
- R11: With offset 4 bit 4 set, a data write raises no `tx_valid`, becomes the received byte with data ready set, leaves offset 5 bits 6 and 5 set and sets the pending flag. Offset 6 then reads bit 7 = offset 4 bit 3, bit 6 = bit 2, bit 5 = bit 0, bit 4 = bit 1, low nibble 0.
- R12: `brk_en` follows offset 3 bit 6 and `data_bits` equals offset 3 bits 1:0 plus 5.
- R13: Offset 7 returns the last byte written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle; read side effects occur at its edge |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |
| tx_byte | output | 8 | Byte to send |
| tx_valid | output | 1 | One-cycle send strobe |
| tx_done | input | 1 | Shifter finished a byte |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive holding register free |
| brk_rx | input | 1 | Break condition received |
| brk_en | output | 1 | Drive break on the line |
| data_bits | output | 4 | Word length, 5 to 8 |
| divisor | output | 16 | Baud divisor |

## Verification
`rdata` is combinational, so a read's value is due in the same cycle as its strobe, and the bench samples it 1 ns after the negative edge it drives the strobe on. Every register update, including a read's side effect, `irq`, `rx_ready` and `tx_valid`, is due one edge after the strobe. The bench drops each strobe and samples these results at the following negative edge, before it drives anything new. The priority and clear-on-read cases are checked by sequences of back-to-back reads of offset 2.

// File: rtl/sercon_pkg.sv
package sercon_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned DIV_W  = 2 * BYTE_W;
    localparam int unsigned WLEN_BASE = 5;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA = 3'd0,
        OFS_IEN  = 3'd1,
        OFS_IID  = 3'd2,
        OFS_LFMT = 3'd3,
        OFS_MCTL = 3'd4,
        OFS_LST  = 3'd5,
        OFS_MST  = 3'd6,
        OFS_SCR  = 3'd7
    } ofs_e;

    typedef enum logic [BYTE_W-1:0] {
        IID_NONE = 8'h01,
        IID_THRE = 8'h02,
        IID_RXD  = 8'h04
    } iid_e;

    typedef struct packed {
        logic       dlab;
        logic       brk;
        logic [3:0] fmt;
        logic [1:0] wlen;
    } lfmt_t;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mctl_t;

    typedef struct packed {
        logic msi;
        logic rlsi;
        logic thri;
        logic rdi;
    } ien_t;

    localparam logic [BYTE_W-1:0] MST_IDLE = 8'hB0;

    function automatic logic [BYTE_W-1:0] lst_pack(input logic idle, input logic bi,
                                                   input logic dr);
        return {1'b0, idle, idle, bi, 3'b000, dr};
    endfunction

endpackage

// File: rtl/sercon_rx_hold.sv
module sercon_rx_hold
    import sercon_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         brk_i,
    input  logic         lb_wr_i,
    input  logic [W-1:0] lb_data_i,
    input  logic         rx_valid_i,
    input  logic [W-1:0] rx_data_i,
    input  logic         rd_clr_i,
    output logic [W-1:0] rbr_o,
    output logic         dr_o,
    output logic         bi_o,
    output logic         rx_ready_o
);
    logic [W-1:0] rbr_q;
    logic         dr_q;
    logic         bi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbr_q <= '0;
            dr_q  <= 1'b0;
            bi_q  <= 1'b0;
        end else begin
            if (rd_clr_i) begin
                dr_q <= 1'b0;
                bi_q <= 1'b0;
            end
            if (brk_i) begin
                rbr_q <= '0;
                dr_q  <= 1'b1;
                bi_q  <= 1'b1;
            end else if (lb_wr_i) begin
                rbr_q <= lb_data_i;
                dr_q  <= 1'b1;
            end else if (rx_valid_i && !dr_q) begin
                rbr_q <= rx_data_i;
                dr_q  <= 1'b1;
            end
        end
    end

    assign rbr_o      = rbr_q;
    assign dr_o       = dr_q;
    assign bi_o       = bi_q;
    assign rx_ready_o = !dr_q;
endmodule

// File: rtl/sercon_irq_prio.sv
module sercon_irq_prio
    import sercon_pkg::*;
(
    input  logic en_rxd_i,
    input  logic en_thre_i,
    input  logic dr_i,
    input  logic pend_i,
    output iid_e iid_o,
    output logic irq_o
);
    always_comb begin
        if (dr_i && en_rxd_i)          iid_o = IID_RXD;
        else if (pend_i && en_thre_i)  iid_o = IID_THRE;
        else                           iid_o = IID_NONE;
    end

    assign irq_o = (iid_o != IID_NONE);
endmodule

// File: rtl/sercon_mst_view.sv
module sercon_mst_view
    import sercon_pkg::*;
(
    input  mctl_t             mctl_i,
    output logic [BYTE_W-1:0] mst_o
);
    always_comb begin
        if (mctl_i.loop)
            mst_o = {mctl_i.out2, mctl_i.out1, mctl_i.dtr, mctl_i.rts, 4'b0000};
        else
            mst_o = MST_IDLE;
    end
endmodule

// File: rtl/sercon_regs.sv
module sercon_regs
    import sercon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              brk_rx,
    output logic              brk_en,
    output logic [3:0]        data_bits,
    output logic [DIV_W-1:0]  divisor
);
    ofs_e              ofs;
    lfmt_t             lfmt_q;
    mctl_t             mctl_q;
    ien_t              ien_q;
    logic [BYTE_W-1:0] scr_q;
    logic [DIV_W-1:0]  div_q;
    logic              tx_idle_q;
    logic              tx_pend_q;
    logic              tx_valid_q;
    logic [BYTE_W-1:0] tx_byte_q;

    logic [BYTE_W-1:0] rbr_w;
    logic              dr_w;
    logic              bi_w;
    iid_e              iid_w;
    logic [BYTE_W-1:0] mst_w;

    assign ofs = ofs_e'(addr);

    // decoded strobes
    logic data_wr, data_rd, ien_wr, iid_rd, dll_wr, dlm_wr, lb_wr;
    assign data_wr = wr_en && ofs == OFS_DATA && !lfmt_q.dlab;
    assign dll_wr  = wr_en && ofs == OFS_DATA &&  lfmt_q.dlab;
    assign ien_wr  = wr_en && ofs == OFS_IEN  && !lfmt_q.dlab;
    assign dlm_wr  = wr_en && ofs == OFS_IEN  &&  lfmt_q.dlab;
    assign data_rd = rd_en && ofs == OFS_DATA && !lfmt_q.dlab;
    assign iid_rd  = rd_en && ofs == OFS_IID;
    assign lb_wr   = data_wr && mctl_q.loop;

    sercon_rx_hold #(.W(BYTE_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .brk_i      (brk_rx),
        .lb_wr_i    (lb_wr),
        .lb_data_i  (wdata),
        .rx_valid_i (rx_valid),
        .rx_data_i  (rx_byte),
        .rd_clr_i   (data_rd),
        .rbr_o      (rbr_w),
        .dr_o       (dr_w),
        .bi_o       (bi_w),
        .rx_ready_o (rx_ready)
    );

    sercon_irq_prio u_prio (
        .en_rxd_i  (ien_q.rdi),
        .en_thre_i (ien_q.thri),
        .dr_i      (dr_w),
        .pend_i    (tx_pend_q),
        .iid_o     (iid_w),
        .irq_o     (irq)
    );

    sercon_mst_view u_mst (
        .mctl_i (mctl_q),
        .mst_o  (mst_w)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            lfmt_q <= '0;
            mctl_q <= '0;
            ien_q  <= '0;
            scr_q  <= '0;
            div_q  <= '0;
        end else if (wr_en) begin
            if (dll_wr) div_q[BYTE_W-1:0]     <= wdata;
            if (dlm_wr) div_q[DIV_W-1:BYTE_W] <= wdata;
            if (ien_wr) ien_q                 <= ien_t'(wdata[3:0]);
            case (ofs)
                OFS_LFMT: lfmt_q <= lfmt_t'(wdata);
                OFS_MCTL: mctl_q <= mctl_t'(wdata[4:0]);
                OFS_SCR:  scr_q  <= wdata;
                default: ;
            endcase
        end
    end

    // transmit side and hidden pending flag; later statements take precedence
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_idle_q  <= 1'b1;
            tx_pend_q  <= 1'b0;
            tx_valid_q <= 1'b0;
            tx_byte_q  <= '0;
        end else begin
            tx_valid_q <= 1'b0;
            if (iid_rd && iid_w == IID_THRE) tx_pend_q <= 1'b0;
            if (ien_wr && tx_idle_q)         tx_pend_q <= 1'b1;
            if (tx_done) begin
                tx_idle_q <= 1'b1;
                tx_pend_q <= 1'b1;
            end
            if (data_wr) begin
                if (mctl_q.loop) begin
                    tx_idle_q <= 1'b1;
                    tx_pend_q <= 1'b1;
                end else begin
                    tx_idle_q  <= 1'b0;
                    tx_pend_q  <= 1'b0;
                    tx_valid_q <= 1'b1;
                    tx_byte_q  <= wdata;
                end
            end
        end
    end

    // read mux
    always_comb begin
        case (ofs)
            OFS_DATA: rdata = lfmt_q.dlab ? div_q[BYTE_W-1:0] : rbr_w;
            OFS_IEN:  rdata = lfmt_q.dlab ? div_q[DIV_W-1:BYTE_W] : {4'b0000, ien_q};
            OFS_IID:  rdata = iid_w;
            OFS_LFMT: rdata = lfmt_q;
            OFS_MCTL: rdata = {3'b000, mctl_q};
            OFS_LST:  rdata = lst_pack(tx_idle_q, bi_w, dr_w);
            OFS_MST:  rdata = mst_w;
            default:  rdata = scr_q;
        endcase
    end

    assign tx_valid  = tx_valid_q;
    assign tx_byte   = tx_byte_q;
    assign brk_en    = lfmt_q.brk;
    assign data_bits = 4'(lfmt_q.wlen) + 4'(WLEN_BASE);
    assign divisor   = div_q;
endmodule

// File: rtl/sercon_regs_chk.sv
module sercon_regs_chk
    import sercon_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic              irq,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              tx_valid,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              brk_rx,
    input logic [BYTE_W-1:0] rbr,
    input logic              dr,
    input logic              bi,
    input logic              pend,
    input logic [3:0]        ien,
    input logic              dlab,
    input logic              loop
);
    logic plain_wr;
    assign plain_wr = wr_en && addr == 3'd0 && !dlab;

    AST_TX_STROBE: assert property (@(posedge clk) disable iff (rst)
        plain_wr && !loop |=> tx_valid && tx_byte == $past(wdata)); // R6

    AST_DIV_NO_SEND: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == 3'd0 && dlab |=> !tx_valid); // R2

    AST_LOOP_NO_SEND: assert property (@(posedge clk) disable iff (rst)
        plain_wr && loop |=> !tx_valid); // R11

    AST_LOOP_DELIVER: assert property (@(posedge clk) disable iff (rst)
        plain_wr && loop && !brk_rx |=> dr && rbr == $past(wdata)); // R11

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (dr && ien[0]) || (pend && ien[1])); // R4

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_ready && !brk_rx && !(plain_wr && loop) |=> $stable(rbr)); // R9

    AST_BREAK_LOAD: assert property (@(posedge clk) disable iff (rst)
        brk_rx |=> rbr == '0 && bi && dr); // R10

    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rd_en && !wr_en && addr == 3'd0 && !dlab && !brk_rx |=> !bi && (!dr || $past(rx_valid && rx_ready))); // R8
endmodule

bind sercon_regs sercon_regs_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .irq      (irq),
    .tx_byte  (tx_byte),
    .tx_valid (tx_valid),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .brk_rx   (brk_rx),
    .rbr      (rbr_w),
    .dr       (dr_w),
    .bi       (bi_w),
    .pend     (tx_pend_q),
    .ien      (ien_q),
    .dlab     (lfmt_q.dlab),
    .loop     (mctl_q.loop)
);

// File: tb/sercon_regs_tb.sv
module sercon_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       irq;
    logic [7:0] tx_byte;
    logic       tx_valid;
    logic       tx_done = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_valid = 1'b0;
    logic       rx_ready;
    logic       brk_rx = 1'b0;
    logic       brk_en;
    logic [3:0] data_bits;
    logic [15:0] divisor;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sercon_regs dut_i (.*);

    // {is_read, addr, wdata, expected}
    localparam int NV = 20;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 3'd5, 8'h00, 8'h60},  // R1
        {1'b1, 3'd6, 8'h00, 8'hB0},  // R1
        {1'b1, 3'd2, 8'h00, 8'h01},  // R1
        {1'b1, 3'd3, 8'h00, 8'h00},  // R1
        {1'b1, 3'd1, 8'h00, 8'h00},  // R1
        {1'b1, 3'd7, 8'h00, 8'h00},  // R1
        {1'b1, 3'd4, 8'h00, 8'h00},  // R1
        {1'b0, 3'd7, 8'hA5, 8'h00},
        {1'b1, 3'd7, 8'h00, 8'hA5},  // R13
        {1'b0, 3'd3, 8'h80, 8'h00},
        {1'b0, 3'd0, 8'h34, 8'h00},
        {1'b0, 3'd1, 8'h12, 8'h00},
        {1'b1, 3'd0, 8'h00, 8'h34},  // R2
        {1'b1, 3'd1, 8'h00, 8'h12},  // R2
        {1'b0, 3'd3, 8'h03, 8'h00},
        {1'b1, 3'd1, 8'h00, 8'h00},  // R2 mask untouched
        {1'b1, 3'd3, 8'h00, 8'h03},
        {1'b0, 3'd1, 8'h02, 8'h00},
        {1'b1, 3'd2, 8'h00, 8'h02},  // R7
        {1'b1, 3'd2, 8'h00, 8'h01}   // R5
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        check(req, 16'(rdata), 16'(exp));
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic offer(input logic [7:0] b, input logic exp_ready, input string req);
        @(negedge clk);
        check(req, 16'(rx_ready), 16'(exp_ready));
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R4 reset irq", 16'(irq), 16'd0);
        check("R9 reset ready", 16'(rx_ready), 16'd1);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) bus_rd(VEC[i][18:16], VEC[i][7:0], $sformatf("vec%0d R1/R2/R5/R7/R13", i));
            else            bus_wr(VEC[i][18:16], VEC[i][15:8]);
        end

        check("R2 divisor out", divisor, 16'h1234);
        check("R12 data_bits", 16'(data_bits), 16'd8);
        check("R12 brk_en off", 16'(brk_en), 16'd0);
        bus_wr(3'd3, 8'h42);
        check("R12 brk_en on", 16'(brk_en), 16'd1);
        check("R12 data_bits 7", 16'(data_bits), 16'd7);
        bus_wr(3'd3, 8'h03);

        // R6 transmit path
        bus_wr(3'd0, 8'h5A);
        check("R6 tx_valid", 16'(tx_valid), 16'd1);
        check("R6 tx_byte", 16'(tx_byte), 16'h5A);
        @(negedge clk);
        check("R6 tx_valid single", 16'(tx_valid), 16'd0);
        bus_rd(3'd5, 8'h00, "R6 busy status");
        check("R4 irq low busy", 16'(irq), 16'd0);
        pulse_done();
        check("R4 irq on done", 16'(irq), 16'd1);
        bus_rd(3'd5, 8'h60, "R6 idle status");
        bus_rd(3'd2, 8'h02, "R6 pending after done");
        check("R4 irq after clear", 16'(irq), 16'd0);

        // R3 priority
        bus_wr(3'd1, 8'h03);
        offer(8'h77, 1'b1, "R9 ready free");
        check("R9 ready drops", 16'(rx_ready), 16'd0);
        bus_rd(3'd2, 8'h04, "R3 rx above thre");
        bus_rd(3'd2, 8'h04, "R3 thre read leaves rx");
        offer(8'h88, 1'b0, "R9 held off");
        bus_rd(3'd0, 8'h77, "R9 byte kept");
        bus_rd(3'd5, 8'h60, "R8 dr cleared");
        bus_rd(3'd2, 8'h02, "R3 thre next");
        bus_rd(3'd2, 8'h01, "R5 cleared");

        // R10 break
        @(negedge clk); brk_rx = 1'b1;
        @(negedge clk); brk_rx = 1'b0;
        bus_rd(3'd5, 8'h71, "R10 break status");
        bus_rd(3'd0, 8'h00, "R10 break byte");
        bus_rd(3'd5, 8'h60, "R8 bi cleared");

        // R11 loopback
        bus_wr(3'd4, 8'h1F);
        bus_rd(3'd6, 8'hF0, "R11 msr all");
        bus_wr(3'd4, 8'h15);
        bus_rd(3'd6, 8'h60, "R11 msr out1 dtr");
        bus_wr(3'd4, 8'h1A);
        bus_rd(3'd6, 8'h90, "R11 msr out2 rts");
        bus_wr(3'd0, 8'h3C);
        check("R11 no send", 16'(tx_valid), 16'd0);
        bus_rd(3'd5, 8'h61, "R11 status");
        bus_rd(3'd2, 8'h04, "R11 rx irq");
        bus_rd(3'd0, 8'h3C, "R11 looped byte");
        bus_rd(3'd2, 8'h02, "R11 pending set");
        bus_wr(3'd1, 8'h00);
        check("R4 masked", 16'(irq), 16'd0);
        bus_wr(3'd4, 8'h00);
        bus_rd(3'd6, 8'hB0, "R11 msr normal");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule